// File: doc/BRIEF.md
# Ripple-Carry Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a 32-bit datapath. It is built from a chain of identical one-bit slices. Each slice holds a full adder and a four-way selector, and the carry ripples from the least significant slice to the most significant one. A 3-bit operation code picks bitwise AND, bitwise OR, addition, subtraction or signed set-on-less-than. The unit reports a result word, a zero flag, a signed overflow flag and the carry out of the top slice.

Subtraction reuses the adder. The top bit of the operation code inverts the second operand and also supplies the carry into bit 0, so the adder computes a + ~b + 1. For set-on-less-than the unit subtracts and then corrects the sign of the difference with the overflow flag. It returns that corrected sign in bit 0 of the result and zeros in every other bit. Equality is tested by subtracting and reading the zero flag. The unit has no clock, reset or internal state.

Top module: `ralu_core`

## Requirements
- R1: Opcode 000 returns a AND b, and opcode 001 returns a OR b, bit by bit.
- R2: Opcode 010 returns (a + b) modulo 2^32.
- R3: Opcode 110 returns (a - b) modulo 2^32, formed as a + ~b + 1.
- R4: Opcode 111 returns 1 in bit 0 when a is less than b as signed two's-complement values, and 0 otherwise. Bits 31..1 are 0. The answer stays correct when a - b overflows.
- R5: The zero output is 1 exactly when every result bit is 0. After opcode 110 it is therefore 1 exactly when a equals b.
- R6: Overflow is 1 on addition when a and b share a sign and the sum's sign differs from it. On subtraction and on set-on-less-than it is 1 when a and b differ in sign and the difference's sign differs from a's sign. It is 0 for opcodes 000 and 001.
- R7: For opcodes 010, 110 and 111 the carry output is the carry out of bit 31 of the adder. For subtraction that is 1 when no unsigned borrow occurs. For all other opcodes the carry output is 0.
- R8: Opcodes 011, 100 and 101 give a result of all zeros, overflow 0 and carry 0, so zero reads 1.
- R9: Every output is a function of the present inputs only, with no memory of earlier operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow for add, subtract and compare |
| carry_o | output | 1 | Carry out of the top slice for arithmetic opcodes |

## Verification
Every result of this block is due in the same clock cycle as its stimulus, because there are no registers between inputs and outputs. The bench changes the operands one time unit after a rising edge and reads all four outputs at the following falling edge, half a period later, so the carry chain has settled before each read. Any value left over from an earlier vector would show up as a mismatch, which covers R9. A fixed table of vectors covers the overflow, borrow and compare corners, and a model-checked sweep of random operands and opcodes follows it.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

   typedef enum logic [2:0] {
      OP_AND = 3'b000,
      OP_OR  = 3'b001,
      OP_ADD = 3'b010,
      OP_SUB = 3'b110,
      OP_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      SEL_AND  = 2'd0,
      SEL_OR   = 2'd1,
      SEL_SUM  = 2'd2,
      SEL_LESS = 2'd3
   } slice_sel_e;

endpackage

// File: rtl/ralu_decode.sv
module ralu_decode
   import ralu_pkg::*;
(
   input  logic [2:0] op_i,
   output slice_sel_e sel_o,
   output logic       binv_o,
   output logic       valid_o,
   output logic       arith_o
);

   always_comb begin
      sel_o   = SEL_AND;
      valid_o = 1'b1;
      arith_o = 1'b0;
      unique case (op_i)
         OP_AND: sel_o = SEL_AND;
         OP_OR:  sel_o = SEL_OR;
         OP_ADD: begin sel_o = SEL_SUM;  arith_o = 1'b1; end
         OP_SUB: begin sel_o = SEL_SUM;  arith_o = 1'b1; end
         OP_SLT: begin sel_o = SEL_LESS; arith_o = 1'b1; end
         default: valid_o = 1'b0;
      endcase
   end

   // top opcode bit is both the invert control and the carry into bit 0
   assign binv_o = op_i[2];

endmodule

// File: rtl/ralu_slice.sv
module ralu_slice
   import ralu_pkg::*;
(
   input  logic       a_i,
   input  logic       b_i,
   input  logic       binv_i,
   input  logic       cin_i,
   input  logic       less_i,
   input  slice_sel_e sel_i,
   output logic       res_o,
   output logic       sum_o,
   output logic       cout_o
);

   logic bx;

   assign bx     = b_i ^ binv_i;
   assign sum_o  = a_i ^ bx ^ cin_i;
   assign cout_o = (a_i & bx) | (a_i & cin_i) | (bx & cin_i);

   always_comb begin
      unique case (sel_i)
         SEL_AND:  res_o = a_i & bx;
         SEL_OR:   res_o = a_i | bx;
         SEL_SUM:  res_o = sum_o;
         SEL_LESS: res_o = less_i;
         default:  res_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ralu_ovf.sv
module ralu_ovf (
   input  logic a_msb_i,
   input  logic bx_msb_i,
   input  logic sum_msb_i,
   output logic ovf_o,
   output logic set_o
);

   // operands of equal effective sign whose sum flips sign
   assign ovf_o = (a_msb_i == bx_msb_i) && (sum_msb_i != a_msb_i);
   // sign of the true difference, corrected for overflow
   assign set_o = sum_msb_i ^ ovf_o;

endmodule

// File: rtl/ralu_core.sv
module ralu_core
   import ralu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             ovf_o,
   output logic             carry_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("ralu_core: WIDTH must be at least 2");
   end

   slice_sel_e       sel;
   logic             binv, op_valid, arith;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] sum_w, res_w, less_w;
   logic             ovf_raw, set_w;

   ralu_decode u_dec (
      .op_i    (op_i),
      .sel_o   (sel),
      .binv_o  (binv),
      .valid_o (op_valid),
      .arith_o (arith)
   );

   assign carry[0] = binv;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (i == 0) begin : g_lsb
         assign less_w[i] = set_w;
      end else begin : g_upper
         assign less_w[i] = 1'b0;
      end
      ralu_slice u_bit (
         .a_i    (a_i[i]),
         .b_i    (b_i[i]),
         .binv_i (binv),
         .cin_i  (carry[i]),
         .less_i (less_w[i]),
         .sel_i  (sel),
         .res_o  (res_w[i]),
         .sum_o  (sum_w[i]),
         .cout_o (carry[i+1])
      );
   end

   ralu_ovf u_ovf (
      .a_msb_i   (a_i[MSB]),
      .bx_msb_i  (b_i[MSB] ^ binv),
      .sum_msb_i (sum_w[MSB]),
      .ovf_o     (ovf_raw),
      .set_o     (set_w)
   );

   assign result_o = op_valid ? res_w : '0;
   assign zero_o   = ~|result_o;
   assign ovf_o    = arith & ovf_raw;
   assign carry_o  = arith & carry[WIDTH];

   always_comb begin
      if (op_i == OP_AND)
         a_r1_and_bits: assert (result_o == (a_i & b_i));
      if (op_i == OP_ADD)
         a_r2_add_sum: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}));
      if (op_i == OP_SUB)
         a_r3_sub_diff: assert (result_o == (a_i - b_i));
      if (op_i == OP_SLT)
         a_r4_slt_word: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))});
      if (op_i == OP_SUB)
         a_r5_eq_zero: assert (zero_o == (a_i == b_i));
      if (op_i == OP_AND || op_i == OP_OR)
         a_r6_logic_no_ovf: assert (!ovf_o && !carry_o);
      if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
         a_r8_illegal_quiet: assert (result_o == '0 && !ovf_o && !carry_o && zero_o);
   end

endmodule

// File: tb/sim_ralu_core.sv
module sim_ralu_core;

   localparam int W = 32;
   localparam int NV = 17;

   logic         clk = 1'b0;
   logic [2:0]   op;
   logic [W-1:0] a, b;
   logic [W-1:0] res;
   logic         zero, ovf, carry;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   ralu_core #(.WIDTH(W)) u0 (
      .op_i(op), .a_i(a), .b_i(b),
      .result_o(res), .zero_o(zero), .ovf_o(ovf), .carry_o(carry)
   );

   // {op, a, b, result, zero, ovf, carry}
   localparam logic [101:0] VEC [NV] = '{
      {3'b000, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1'b0, 1'b0, 1'b0},
      {3'b001, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 1'b0, 1'b0, 1'b0},
      {3'b010, 32'h0000_0002, 32'h0000_0006, 32'h0000_0008, 1'b0, 1'b0, 1'b0},
      {3'b010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
      {3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
      {3'b010, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1},
      {3'b110, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
      {3'b110, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0},
      {3'b110, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1},
      {3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
      {3'b111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b1},
      {3'b111, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b1},
      {3'b111, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b0},
      {3'b111, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
      {3'b011, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
      {3'b100, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
      {3'b101, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0}
   };

   function automatic logic [W+2:0] model(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
      logic [W:0]   s;
      logic [W-1:0] r;
      logic         v, c;
      r = '0; v = 1'b0; c = 1'b0;
      case (o)
         3'b000: r = x & y;
         3'b001: r = x | y;
         3'b010: begin
            s = {1'b0, x} + {1'b0, y};
            r = s[W-1:0]; c = s[W];
            v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
         end
         3'b110, 3'b111: begin
            s = {1'b0, x} + {1'b0, ~y} + 1;
            c = s[W];
            v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
            r = (o == 3'b110) ? s[W-1:0] : {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
         end
         default: ;
      endcase
      return {r, (r == '0), v, c};
   endfunction

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h (op=%b a=%h b=%h)", tag, act, exp, op, a, b);
      end
   endtask

   function automatic string res_tag(logic [2:0] o);
      case (o)
         3'b000, 3'b001: return "R1 logic result";
         3'b010:         return "R2 add result";
         3'b110:         return "R3 sub result";
         3'b111:         return "R4 slt result";
         default:        return "R8 illegal result";
      endcase
   endfunction

   task automatic run(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y, logic [W+2:0] exp);
      @(posedge clk);
      #1;
      op = o; a = x; b = y;
      @(negedge clk);
      chk(res_tag(o), res, exp[W+2:3]);
      chk("R5 zero", {31'd0, zero}, {31'd0, exp[2]});
      chk((o == 3'b011 || o == 3'b100 || o == 3'b101) ? "R8 overflow" : "R6 overflow",
          {31'd0, ovf}, {31'd0, exp[1]});
      chk("R7 carry", {31'd0, carry}, {31'd0, exp[0]});
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete (got timeout, expected completion)");
      finish_run();
   end

   initial begin
      op = 3'b000; a = '0; b = '0;
      @(negedge clk);
      // initial state with all-zero inputs: AND of zeros
      chk("R1 initial result", res, '0);
      chk("R5 initial zero", {31'd0, zero}, 32'd1);
      chk("R6 initial overflow", {31'd0, ovf}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run(VEC[i][101:99], VEC[i][98:67], VEC[i][66:35], VEC[i][34:0]);
      end

      // R9: repeat an earlier vector after different ones, result must not change
      run(3'b111, 32'h8000_0000, 32'h7FFF_FFFF, {32'h1, 1'b0, 1'b1, 1'b1});
      run(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, {32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0});
      run(3'b111, 32'h8000_0000, 32'h7FFF_FFFF, {32'h1, 1'b0, 1'b1, 1'b1});

      for (int i = 0; i < 400; i++) begin
         logic [2:0]   ro;
         logic [W-1:0] ra, rb;
         ro = 3'($urandom % 8);
         ra = $urandom;
         rb = (i % 5 == 0) ? ra : $urandom;
         run(ro, ra, rb, model(ro, ra, rb));
      end

      finish_run();
   end

endmodule